// File: doc/BRIEF.md
# Firmware Glue Register Bank

This block is a small register bank on a byte-addressed bus. Boot firmware uses it for four services. It can request a halt that carries an 8-bit exit code. It can learn which processor issued an access and how many processors are active. It can drive a level interrupt line to any processor. Only the low six address bits are decoded, so the bank repeats every 64 bytes across whatever window the bus gives it.

Each bus access is a single request cycle, marked by `req_valid`. The bank takes a request in every cycle and has no back-pressure, so it has no ready signal. Read data is registered and appears in the cycle after the read. It then holds until the next read. Byte lane 0 (`req_wdata[7:0]`) is the byte at the lowest address, and lane 1 (`req_wdata[15:8]`) is the byte at the next address. Read values are returned in lane 0, with the upper lane zero.

Top module: `glue_regs`

## Requirements
- R1: Only `req_addr[5:0]` is decoded. An access at any address whose low six bits equal a register offset behaves exactly like an access at that offset.
- R2: A write at offset 0x00 makes `halt_pulse` high for exactly the one cycle after the write. In that same cycle, `halt_code` shows lane 0 of the written data.
- R3: `halt_code` changes only together with a halt pulse and holds its value between halt writes. It is 0 after reset.
- R4: A read at offset 0x04 returns `req_cpu` of that read in lane 0.
- R5: A read at offset 0x0A returns the active processor count. The count is `MP_COUNT`, or 1 when `MP_COUNT` is 0 (the default).
- R6: A write at offset 0x08 with `req_bytes` of 2 or more selects port = lane 0 and level = lane 1. Line `irq_lines[port]` becomes 1 when the level is nonzero and 0 when it is zero.
- R7: A write at offset 0x08 with `req_bytes` of 1 selects the port from lane 0 and drives level 0 onto it, ignoring lane 1.
- R8: Each interrupt line holds its value until a write at offset 0x08 selects it. Writes at other offsets leave every line unchanged. All lines are 0 after reset.
- R9: A write at offset 0x08 whose port is NCPU or more changes no interrupt line.
- R10: Reads at any offset other than 0x04 and 0x0A return 0. Writes at any offset other than 0x00 and 0x08 change no output.
- R11: `rd_data` is 0 after reset. It loads only in the cycle after a read and holds through all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data, lane 0 = lowest address |
| req_bytes | input | 3 | Number of bytes written (1 to 4) |
| req_cpu | input | CPU_W | Index of the requesting processor |
| rd_data | output | 16 | Registered read data |
| halt_pulse | output | 1 | One-cycle halt request |
| halt_code | output | 8 | Exit status of the last halt |
| irq_lines | output | NCPU | Level interrupt line per processor |

## Verification
The assertions assume that `req_write`, `req_addr`, `req_wdata` and `req_bytes` are meaningful only while `req_valid` is high. They also assume that `req_cpu` is below NCPU on reads of offset 0x04. The stimulus drives one request per task on a falling edge and drops `req_valid` after a single cycle. It always gives an in-range processor index. Out-of-range ports appear only as interrupt write data, where the design must ignore them.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam int OFS_W = 6;
  localparam logic [OFS_W-1:0] OFS_HALT  = 6'h00;
  localparam logic [OFS_W-1:0] OFS_CPUID = 6'h04;
  localparam logic [OFS_W-1:0] OFS_IRQ   = 6'h08;
  localparam logic [OFS_W-1:0] OFS_COUNT = 6'h0A;

  typedef struct packed {
    logic halt_wr;
    logic irq_wr;
    logic id_rd;
    logic cnt_rd;
    logic any_rd;
  } sel_t;
endpackage

// File: rtl/glue_decode.sv
module glue_decode
  import glue_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);
  logic [OFS_W-1:0] ofs;
  assign ofs = addr[OFS_W-1:0];

  always_comb begin
    sel         = '0;
    sel.any_rd  = valid && !write;
    sel.halt_wr = valid && write && (ofs == OFS_HALT);
    sel.irq_wr  = valid && write && (ofs == OFS_IRQ);
    sel.id_rd   = valid && !write && (ofs == OFS_CPUID);
    sel.cnt_rd  = valid && !write && (ofs == OFS_COUNT);
  end
endmodule

// File: rtl/glue_halt.sv
module glue_halt #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CODE_W-1:0] code_in,
  output logic              pulse,
  output logic [CODE_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      code  <= '0;
    end else begin
      pulse <= fire;
      if (fire) code <= code_in;
    end
  end

  assert_halt_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pulse && code == $past(code_in)));
  assert_halt_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !pulse);
  assert_code_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse |-> $stable(code));
endmodule

// File: rtl/glue_irq_bank.sv
module glue_irq_bank #(
  parameter int NCPU   = 4,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] port,
  input  logic              level,
  output logic [NCPU-1:0]   lines
);
  for (genvar i = 0; i < NCPU; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)                                       lines[i] <= 1'b0;
      else if (wr_en && port == PORT_W'(i))             lines[i] <= level;
    end
  end

  assert_lines_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lines));
  assert_port_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port >= PORT_W'(NCPU)) |=> $stable(lines));
  assert_one_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $countones(lines ^ $past(lines)) <= 1);
endmodule

// File: rtl/glue_regs.sv
module glue_regs
  import glue_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NCPU     = 4,
  parameter int MP_COUNT = 0,
  parameter int CPU_W    = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [2:0]        req_bytes,
  input  logic [CPU_W-1:0]  req_cpu,
  output logic [15:0]       rd_data,
  output logic              halt_pulse,
  output logic [7:0]        halt_code,
  output logic [NCPU-1:0]   irq_lines
);
  localparam int ACTIVE = (MP_COUNT == 0) ? 1 : MP_COUNT;

  sel_t        sel;
  logic        level;
  logic [15:0] rd_next;

  glue_decode #(.ADDR_W(ADDR_W)) u_decode (
    .valid (req_valid),
    .write (req_write),
    .addr  (req_addr),
    .sel   (sel)
  );

  glue_halt #(.CODE_W(8)) u_halt (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (sel.halt_wr),
    .code_in (req_wdata[7:0]),
    .pulse   (halt_pulse),
    .code    (halt_code)
  );

  assign level = (req_bytes >= 3'd2) && (req_wdata[15:8] != 8'h00);

  glue_irq_bank #(.NCPU(NCPU), .PORT_W(8)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (sel.irq_wr),
    .port  (req_wdata[7:0]),
    .level (level),
    .lines (irq_lines)
  );

  always_comb begin
    rd_next = '0;
    if (sel.id_rd)  rd_next = 16'(req_cpu);
    if (sel.cnt_rd) rd_next = 16'(ACTIVE[7:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          rd_data <= '0;
    else if (sel.any_rd) rd_data <= rd_next;
  end

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rd_data));
  assert_cpu_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[5:0] == 6'h04)
      |=> rd_data == 16'($past(req_cpu)));
  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:8] == 8'h00);
endmodule

// File: tb/test_glue_regs.sv
`timescale 1ns/1ps
module test_glue_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [2:0]  req_bytes = '0;
  logic [1:0]  req_cpu = '0;
  logic [15:0] rd_data;
  logic        halt_pulse;
  logic [7:0]  halt_code;
  logic [3:0]  irq_lines;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  glue_regs #(.ADDR_W(16), .NCPU(4), .MP_COUNT(0)) i_glue_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bytes(req_bytes),
    .req_cpu(req_cpu), .rd_data(rd_data), .halt_pulse(halt_pulse),
    .halt_code(halt_code), .irq_lines(irq_lines)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [2:0] n, input logic [1:0] cpu);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    req_wdata = d; req_bytes = n; req_cpu = cpu;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic t_reset;
    chk("R3 reset code", 32'(halt_code), 0);
    chk("R8 reset lines", 32'(irq_lines), 0);
    chk("R11 reset rd_data", 32'(rd_data), 0);
    chk("R2 reset pulse", 32'(halt_pulse), 0);
  endtask

  task automatic t_halt;
    access(1'b1, 16'h0000, 16'h1A5C, 3'd1, 2'd0);
    chk("R2 pulse high", 32'(halt_pulse), 1);
    chk("R2 code", 32'(halt_code), 32'h5C);
    @(negedge clk);
    chk("R2 pulse one cycle", 32'(halt_pulse), 0);
    chk("R3 code held", 32'(halt_code), 32'h5C);
    access(1'b1, 16'h0040, 16'h0033, 3'd4, 2'd1);
    chk("R1 alias halt pulse", 32'(halt_pulse), 1);
    chk("R1 alias halt code", 32'(halt_code), 32'h33);
  endtask

  task automatic t_reads;
    access(1'b0, 16'h0004, 16'h0000, 3'd1, 2'd3);
    chk("R4 cpu id 3", 32'(rd_data), 3);
    access(1'b0, 16'h1244, 16'h0000, 3'd1, 2'd2);
    chk("R1 R4 alias cpu id", 32'(rd_data), 2);
    repeat (3) @(negedge clk);
    chk("R11 rd_data held", 32'(rd_data), 2);
    access(1'b0, 16'h000A, 16'h0000, 3'd1, 2'd1);
    chk("R5 count default", 32'(rd_data), 1);
    access(1'b0, 16'h0008, 16'h0000, 3'd1, 2'd1);
    chk("R10 unmapped read 08", 32'(rd_data), 0);
    access(1'b0, 16'h000A, 16'h0000, 3'd1, 2'd1);
    access(1'b0, 16'h0010, 16'h0000, 3'd1, 2'd1);
    chk("R10 unmapped read 10", 32'(rd_data), 0);
  endtask

  task automatic t_irq;
    access(1'b1, 16'h0008, 16'h0102, 3'd2, 2'd0);
    chk("R6 set port 2", 32'(irq_lines), 32'b0100);
    access(1'b1, 16'h0008, 16'hFF00, 3'd2, 2'd0);
    chk("R6 set port 0", 32'(irq_lines), 32'b0101);
    access(1'b1, 16'h0008, 16'h0002, 3'd2, 2'd0);
    chk("R6 clear port 2", 32'(irq_lines), 32'b0001);
    access(1'b1, 16'h0008, 16'h0103, 3'd2, 2'd0);
    access(1'b1, 16'h0008, 16'h0103, 3'd1, 2'd0);
    chk("R7 single byte clears", 32'(irq_lines), 32'b0001);
    access(1'b1, 16'h0008, 16'h0104, 3'd2, 2'd0);
    chk("R9 port 4 ignored", 32'(irq_lines), 32'b0001);
    access(1'b1, 16'h0008, 16'h01FF, 3'd2, 2'd0);
    chk("R9 port FF ignored", 32'(irq_lines), 32'b0001);
    access(1'b1, 16'h3FC8, 16'h0101, 3'd2, 2'd0);
    chk("R1 alias irq", 32'(irq_lines), 32'b0011);
    repeat (4) @(negedge clk);
    chk("R8 lines hold", 32'(irq_lines), 32'b0011);
  endtask

  task automatic t_ignored;
    access(1'b1, 16'h000C, 16'h0102, 3'd2, 2'd0);
    chk("R10 unmapped write no halt", 32'(halt_pulse), 0);
    chk("R10 unmapped write lines", 32'(irq_lines), 32'b0011);
    chk("R10 unmapped write code", 32'(halt_code), 32'h33);
    access(1'b1, 16'h0000, 16'h0102, 3'd2, 2'd0);
    chk("R8 halt write keeps lines", 32'(irq_lines), 32'b0011);
    access(1'b0, 16'h0004, 16'h0000, 3'd1, 2'd1);
    access(1'b1, 16'h0004, 16'h00EE, 3'd1, 2'd0);
    chk("R10 write to id reg", 32'(rd_data), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_halt();
    t_reads();
    t_irq();
    t_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule